// File: doc/BRIEF.md
# Packed Narrowing and Word Shuffle Unit

This block is a 64-bit packed-data execution slice. It takes two operands, a source and a destination, and either narrows their elements into one result (doublewords to words, or words to bytes) or rearranges the 16-bit words of the source under control of an 8-bit immediate. When narrowing, each element is reduced in one of three ways: clamped as a signed value, clamped as an unsigned value, or cut down to its low bits.

All the arithmetic is combinational. The result passes through a single output register. A caller presents an opcode, an immediate and both operands with an input valid, and reads the result and an error flag one cycle later. A new operation can be issued every cycle. When no operation is presented, the last result stays on the output.

Top module: `pksh_unit`

## Requirements
- R1: The 3-bit opcode selects the operation: 0 doubleword-to-word signed saturate, 1 doubleword-to-word unsigned saturate, 2 doubleword-to-word truncate, 3 word-to-byte signed saturate, 4 word-to-byte unsigned saturate, 5 word-to-byte truncate, 6 word shuffle, 7 unused.
- R2: In a doubleword-to-word pack, result words 0 and 1 come from destination doublewords 0 and 1, and result words 2 and 3 come from source doublewords 0 and 1.
- R3: In a word-to-byte pack, result bytes 0 to 3 come from destination words 0 to 3, and result bytes 4 to 7 come from source words 0 to 3.
- R4: Signed saturation reads each input element as two's complement. Values above the narrow signed maximum give 0x7FFF or 0x7F. Values below the narrow signed minimum give 0x8000 or 0x80. All other values keep their low bits.
- R5: Unsigned saturation reads each input element as two's complement. Negative values give zero. Values above the narrow all-ones value give all ones (0xFFFF or 0xFF). All other values keep their low bits.
- R6: Truncation keeps the low half of each input element, whatever its value.
- R7: In the word shuffle (opcode 6), result word k equals source word n, where n = imm[2k+1:2k]. The destination is not used.
- R8: Opcode 7 returns an all-zero result with the error flag set for that one output cycle. Every legal opcode returns with the error flag clear.
- R9: Result, error flag and output valid appear on the clock edge after the one that samples an input with valid high. Output valid equals the input valid delayed by one cycle.
- R10: While input valid is low, the result register holds its last value and the error flag is low.
- R11: Synchronous reset clears output valid, error flag and result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code |
| imm_i | input | 8 | Shuffle lane indices, 2 bits per result word |
| src_i | input | 64 | Source operand |
| dst_i | input | 64 | Destination operand |
| vld_o | output | 1 | Result valid, one cycle after vld_i |
| res_o | output | 64 | Registered result |
| err_o | output | 1 | Unused opcode reported with this result |

## Verification
Two functions can meet in one cycle. The output register presents the result of one operation on the same edge that it captures the next one. Also, a set error flag must clear when a legal operation directly follows an unused one. The bench provokes both by issuing back-to-back operations with no idle cycle: an unused opcode, then a pack, then a shuffle. It checks at every cycle that the flag and data belong to the operation issued one cycle earlier, so nothing carries over from its neighbour. The saturation boundaries are driven at exactly one above and one below each clamp point, in both halves of the operands.

// File: rtl/pksh_pkg.sv
package pksh_pkg;

    localparam int OP_W  = 3;
    localparam int IMM_W = 8;

    typedef enum logic [OP_W-1:0] {
        OP_PKDW_SS = 3'd0,
        OP_PKDW_US = 3'd1,
        OP_PKDW_TR = 3'd2,
        OP_PKWB_SS = 3'd3,
        OP_PKWB_US = 3'd4,
        OP_PKWB_TR = 3'd5,
        OP_SHUF    = 3'd6,
        OP_BAD     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        NM_SSAT  = 2'd0,
        NM_USAT  = 2'd1,
        NM_TRUNC = 2'd2
    } nmode_e;

    typedef enum logic [1:0] {
        K_PDW  = 2'd0,
        K_PWB  = 2'd1,
        K_SHUF = 2'd2,
        K_BAD  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e  kind;
        nmode_e mode;
    } dec_t;

    function automatic dec_t decode(input logic [OP_W-1:0] op);
        dec_t d;
        d.kind = K_BAD;
        d.mode = NM_TRUNC;
        case (op_e'(op))
            OP_PKDW_SS: begin d.kind = K_PDW;  d.mode = NM_SSAT;  end
            OP_PKDW_US: begin d.kind = K_PDW;  d.mode = NM_USAT;  end
            OP_PKDW_TR: begin d.kind = K_PDW;  d.mode = NM_TRUNC; end
            OP_PKWB_SS: begin d.kind = K_PWB;  d.mode = NM_SSAT;  end
            OP_PKWB_US: begin d.kind = K_PWB;  d.mode = NM_USAT;  end
            OP_PKWB_TR: begin d.kind = K_PWB;  d.mode = NM_TRUNC; end
            OP_SHUF:    begin d.kind = K_SHUF; d.mode = NM_TRUNC; end
            default:    begin d.kind = K_BAD;  d.mode = NM_TRUNC; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pksh_narrow.sv
module pksh_narrow
    import pksh_pkg::*;
#(
    parameter int IN_W  = 32,
    parameter int LANES = 4
) (
    input  nmode_e                         mode_i,
    input  logic [LANES*IN_W-1:0]          in_i,
    output logic [LANES*(IN_W/2)-1:0]      out_o
);
    localparam int OUT_W = IN_W / 2;
    localparam logic signed [IN_W-1:0] SMAX =
        {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] SMIN =
        {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic signed [IN_W-1:0] UMAX =
        {{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [IN_W-1:0] x;
        logic [OUT_W-1:0]       y;

        assign x = in_i[i*IN_W +: IN_W];

        always_comb begin
            case (mode_i)
                NM_SSAT: begin
                    if (x > SMAX)      y = {1'b0, {(OUT_W-1){1'b1}}};
                    else if (x < SMIN) y = {1'b1, {(OUT_W-1){1'b0}}};
                    else               y = x[OUT_W-1:0];
                end
                NM_USAT: begin
                    if (x[IN_W-1])     y = '0;
                    else if (x > UMAX) y = '1;
                    else               y = x[OUT_W-1:0];
                end
                default:               y = x[OUT_W-1:0];
            endcase
        end

        assign out_o[i*OUT_W +: OUT_W] = y;
    end

endmodule

// File: rtl/pksh_shuffle.sv
module pksh_shuffle #(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic [LANES*$clog2(LANES)-1:0] sel_i,
    input  logic [LANES*LANE_W-1:0]        in_i,
    output logic [LANES*LANE_W-1:0]        out_o
);
    localparam int IDX_W = $clog2(LANES);

    for (genvar k = 0; k < LANES; k++) begin : g_word
        logic [IDX_W-1:0] idx;
        assign idx = sel_i[k*IDX_W +: IDX_W];
        assign out_o[k*LANE_W +: LANE_W] = in_i[int'(idx)*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/pksh_unit.sv
module pksh_unit
    import pksh_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] res_o,
    output logic              err_o
);
    localparam int DW_W     = 32;
    localparam int WD_W     = 16;
    localparam int DW_LANES = 2 * DATA_W / DW_W;
    localparam int WD_LANES = 2 * DATA_W / WD_W;
    localparam int SH_LANES = DATA_W / WD_W;

    dec_t              dec;
    logic [DATA_W-1:0] pdw_res;
    logic [DATA_W-1:0] pwb_res;
    logic [DATA_W-1:0] shf_res;
    logic [DATA_W-1:0] res_n;
    logic              err_n;

    assign dec = decode(op_i);

    // destination fills the low lanes, source the high lanes
    pksh_narrow #(.IN_W(DW_W), .LANES(DW_LANES)) u_pdw (
        .mode_i (dec.mode),
        .in_i   ({src_i, dst_i}),
        .out_o  (pdw_res)
    );

    pksh_narrow #(.IN_W(WD_W), .LANES(WD_LANES)) u_pwb (
        .mode_i (dec.mode),
        .in_i   ({src_i, dst_i}),
        .out_o  (pwb_res)
    );

    pksh_shuffle #(.LANE_W(WD_W), .LANES(SH_LANES)) u_shf (
        .sel_i  (imm_i[SH_LANES*$clog2(SH_LANES)-1:0]),
        .in_i   (src_i),
        .out_o  (shf_res)
    );

    always_comb begin
        err_n = 1'b0;
        case (dec.kind)
            K_PDW:   res_n = pdw_res;
            K_PWB:   res_n = pwb_res;
            K_SHUF:  res_n = shf_res;
            default: begin
                res_n = '0;
                err_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            err_o <= 1'b0;
            res_o <= '0;
        end else begin
            vld_o <= vld_i;
            err_o <= vld_i & err_n;
            if (vld_i) res_o <= res_n;
        end
    end

endmodule

// File: rtl/pksh_chk.sv
module pksh_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              vld_i,
    input logic [2:0]        op_i,
    input logic [7:0]        imm_i,
    input logic [DATA_W-1:0] src_i,
    input logic [DATA_W-1:0] dst_i,
    input logic              vld_o,
    input logic [DATA_W-1:0] res_o,
    input logic              err_o
);
    // R9
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (vld_o == $past(vld_i)));

    // R8
    bad_op_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i == 3'd7) |=> (err_o && res_o == '0));

    // R8
    good_op_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i != 3'd7) |=> !err_o);

    // R10
    hold_res_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> ($stable(res_o) && !err_o));

    // R6
    trunc_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i == 3'd5) |=> (res_o[7:0] == $past(dst_i[7:0])));

    // R7
    shuf_ident_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_i && op_i == 3'd6 && imm_i == 8'hE4) |=> (res_o == $past(src_i)));

endmodule

bind pksh_unit pksh_chk #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .vld_i (vld_i),
    .op_i  (op_i),
    .imm_i (imm_i),
    .src_i (src_i),
    .dst_i (dst_i),
    .vld_o (vld_o),
    .res_o (res_o),
    .err_o (err_o)
);

// File: tb/tb_pksh_unit.sv
module tb_pksh_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [7:0]  imm_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] dst_i = '0;
    logic        vld_o;
    logic [63:0] res_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pksh_unit dut (
        .clk(clk), .rst(rst), .vld_i(vld_i), .op_i(op_i), .imm_i(imm_i),
        .src_i(src_i), .dst_i(dst_i), .vld_o(vld_o), .res_o(res_o), .err_o(err_o)
    );

    // independent model from the requirements
    function automatic longint narrow(input longint v, input int ow, input int mode);
        longint smax = (longint'(1) <<< (ow - 1)) - 1;
        longint smin = -(longint'(1) <<< (ow - 1));
        longint umax = (longint'(1) <<< ow) - 1;
        if (mode == 0) begin
            if (v > smax) return smax;
            if (v < smin) return smin & umax;
            return v & umax;
        end else if (mode == 1) begin
            if (v < 0) return 0;
            if (v > umax) return umax;
            return v;
        end
        return v & umax;
    endfunction

    function automatic logic [63:0] model(input logic [2:0] op, input logic [7:0] imm,
                                          input logic [63:0] s, input logic [63:0] d);
        logic [63:0] r = '0;
        int mode = op % 3;
        if (op <= 3'd2) begin
            for (int i = 0; i < 2; i++) begin
                r[i*16 +: 16]     = 16'(narrow(longint'($signed(d[i*32 +: 32])), 16, mode));
                r[(i+2)*16 +: 16] = 16'(narrow(longint'($signed(s[i*32 +: 32])), 16, mode));
            end
        end else if (op <= 3'd5) begin
            for (int i = 0; i < 4; i++) begin
                r[i*8 +: 8]     = 8'(narrow(longint'($signed(d[i*16 +: 16])), 8, mode));
                r[(i+4)*8 +: 8] = 8'(narrow(longint'($signed(s[i*16 +: 16])), 8, mode));
            end
        end else if (op == 3'd6) begin
            for (int k = 0; k < 4; k++) begin
                int n = int'(imm[2*k +: 2]);
                r[k*16 +: 16] = s[n*16 +: 16];
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [7:0] imm,
                         input logic [63:0] s, input logic [63:0] d);
        vld_i = 1'b1; op_i = op; imm_i = imm; src_i = s; dst_i = d;
    endtask

    // issue one op, check it one cycle later
    task automatic one(input string tag, input logic [2:0] op, input logic [7:0] imm,
                       input logic [63:0] s, input logic [63:0] d);
        @(negedge clk);
        drive(op, imm, s, d);
        @(negedge clk);
        vld_i = 1'b0;
        check({tag, " R9 vld"}, {63'd0, vld_o}, 64'd1);
        check({tag, " R8 err"}, {63'd0, err_o}, {63'd0, op == 3'd7});
        check(tag, res_o, model(op, imm, s, d));
    endtask

    task automatic t_reset();
        check("R11 vld", {63'd0, vld_o}, 64'd0);
        check("R11 err", {63'd0, err_o}, 64'd0);
        check("R11 res", res_o, 64'd0);
    endtask

    task automatic t_pack_dw();
        logic [63:0] s = {32'hFFFF_7FFF, 32'h0000_8000};
        logic [63:0] d = {32'hFFFF_8000, 32'h0000_7FFF};
        one("R2 R4 dw ssat", 3'd0, 8'h00, s, d);
        check("R4 dw ssat exact", res_o, 64'h8000_7FFF_8000_7FFF);
        one("R2 R5 dw usat", 3'd1, 8'h00, s, d);
        check("R5 dw usat exact", res_o, 64'h0000_8000_0000_7FFF);
        one("R6 dw trunc", 3'd2, 8'h00, s, d);
        check("R6 dw trunc exact", res_o, 64'h7FFF_8000_8000_7FFF);
        one("R2 dw usat big", 3'd1, 8'h00, {32'h0001_0000, 32'h0000_FFFF}, {32'h1234_5678, 32'h0000_0001});
        check("R5 dw usat clamp", res_o, 64'hFFFF_FFFF_FFFF_0001);
    endtask

    task automatic t_pack_wb();
        logic [63:0] s = {16'hFF7F, 16'h0080, 16'hFF80, 16'h007F};
        logic [63:0] d = {16'h0100, 16'h00FF, 16'hFFFF, 16'h0000};
        one("R3 R4 wb ssat", 3'd3, 8'h00, s, d);
        check("R4 wb ssat exact", res_o, 64'h807F_807F_7F7F_FF00);
        one("R3 R5 wb usat", 3'd4, 8'h00, s, d);
        check("R5 wb usat exact", res_o, 64'h0080_007F_FFFF_0000);
        one("R6 wb trunc", 3'd5, 8'h00, s, d);
        check("R6 wb trunc exact", res_o, 64'h7F80_807F_00FF_FF00);
    endtask

    task automatic t_shuffle();
        logic [63:0] s = 64'h4444_3333_2222_1111;
        one("R7 shuf id", 3'd6, 8'hE4, s, 64'hDEAD_BEEF_0BAD_F00D);
        check("R7 shuf id exact", res_o, s);
        one("R7 shuf rev", 3'd6, 8'h1B, s, '0);
        check("R7 shuf rev exact", res_o, 64'h1111_2222_3333_4444);
        one("R7 shuf bcast0", 3'd6, 8'h00, s, '1);
        one("R7 shuf bcast3", 3'd6, 8'hFF, s, '1);
        one("R7 shuf swap", 3'd6, 8'h4E, s, '0);
        check("R7 shuf swap exact", res_o, 64'h2222_1111_4444_3333);
    endtask

    task automatic t_illegal();
        one("R8 R1 op7", 3'd7, 8'hFF, '1, '1);
        check("R8 op7 zero", res_o, 64'd0);
    endtask

    task automatic t_hold();
        logic [63:0] held;
        one("R10 seed", 3'd2, 8'h00, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        held = res_o;
        @(negedge clk);
        op_i = 3'd7; src_i = '1; dst_i = '1; imm_i = 8'h55;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 hold res", res_o, held);
            check("R10 vld low", {63'd0, vld_o}, 64'd0);
            check("R10 err low", {63'd0, err_o}, 64'd0);
        end
    endtask

    task automatic t_b2b();
        logic [63:0] s = 64'h8000_0000_7FFF_FFFF;
        logic [63:0] d = 64'h0000_0001_FFFF_FFFF;
        @(negedge clk);
        drive(3'd7, 8'h00, s, d);
        @(negedge clk);
        check("R8 b2b bad err", {63'd0, err_o}, 64'd1);
        check("R8 b2b bad res", res_o, 64'd0);
        drive(3'd0, 8'h00, s, d);
        @(negedge clk);
        check("R8 b2b err cleared", {63'd0, err_o}, 64'd0);
        check("R9 b2b pack", res_o, model(3'd0, 8'h00, s, d));
        drive(3'd6, 8'h39, s, d);
        @(negedge clk);
        vld_i = 1'b0;
        check("R9 b2b vld", {63'd0, vld_o}, 64'd1);
        check("R7 b2b shuf", res_o, model(3'd6, 8'h39, s, d));
        @(negedge clk);
        check("R9 b2b vld drop", {63'd0, vld_o}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pack_dw();
        t_pack_wb();
        t_shuffle();
        t_illegal();
        t_hold();
        t_b2b();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule